// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block sits at the front of a NAND flash device model. It watches bus writes qualified by the command-latch, address-latch and active-low chip-enable lines, keeps the current command byte and gathers up to five address bytes into a 40-bit address register. Legacy read-pointer commands are folded into a plain read with a column offset. The block decides, on each command or address write, whether an operation starts, and sends a one-cycle start pulse with a decoded operation code to the array engine and the status responder, which live elsewhere.

The point at which a read or a program setup starts depends on the device class and capacity. Small-page parts start on the third address byte. Large-page parts start on the fourth byte up to 1 Gbit and on the fifth byte from 2 Gbit. Page layout, bus width and capacity are parameters. Command and address bytes always travel on the low byte lane of the bus. A wider bus only changes how the column is scaled.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write is taken as a command only when `wr_i`=1, `ce_ni`=0 and `cle_i`=1. A write with `ce_ni`=1 and `ale_i`=0 changes no output. A write with neither `cle_i` nor `ale_i` also changes no output.
- R2: A write with `ale_i`=1 stores `data_i` in `addr_o[8*n +: 8]`, where n is `addr_cnt_o` before the write, and then increments `addr_cnt_o`. Once the count reaches 5, further address bytes are dropped and the count stays at 5.
- R3: Command 0x01 becomes read 0x00 with `col_off_o`=0x100. Command 0x50 becomes read 0x00 with `col_off_o`=PAGE_BYTES. Command 0x00 sets `col_off_o` to 0.
- R4: When LARGE_PAGE=1, a command 0x30 that arrives while the current command is 0x00 is ignored: there is no start, no illegal flag and no change of state. When LARGE_PAGE=1, command 0x05 clears `addr_o[15:0]` and the address count, and leaves `cmd_o` unchanged.
- R5: When the second address byte is stored, the whole address is shifted left by BUS_BYTES-1.
- R6: Read (0x00) and program setup (0x80) start when the address count reaches a trigger value. The trigger is 3 when LARGE_PAGE=0, 4 when LARGE_PAGE=1 and CHIP_MBIT<2048, and 5 when LARGE_PAGE=1 and CHIP_MBIT>=2048.
- R7: Read ID (0x90) starts when its first address byte is stored.
- R8: The following commands start as soon as they are latched: 0x70 status, 0x10 program confirm, 0x60 erase setup, 0xD0 erase confirm, 0xE0 and 0x35 random-read confirm, and 0xFF reset.
- R9: Every accepted command clears the address count, except 0xE0, which keeps it.
- R10: A command byte outside the known set raises `illegal_o` for one cycle and changes no other state. The known set is 0x00, 0x01, 0x50, 0x90, 0x80, the immediate commands, and, when LARGE_PAGE=1, 0x05 and 0x30 after read.
- R11: `start_o` and `illegal_o` are one-cycle pulses that appear in the cycle after the triggering write. `op_o` is 0 when no start is signalled. During a start, `op_o` is 1 for read, 2 for read ID, 3 for status, 4 for program setup, 5 for program confirm, 6 for erase setup, 7 for erase confirm, 8 for random read and 9 for reset.
- R12: Command 0xFF starts op 9 and returns `cmd_o` to 0x00, with the address, the count and the column offset all set to 0.
- R13: After `rst_ni` falls, `cmd_o`, `addr_o`, `addr_cnt_o`, `col_off_o`, `start_o`, `op_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per byte |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| data_i | input | 8 | Command or address byte (low lane) |
| cmd_o | output | 8 | Current command |
| addr_o | output | 8*ADDR_BYTES | Collected address |
| addr_cnt_o | output | clog2(ADDR_BYTES+1) | Address bytes taken |
| col_off_o | output | clog2(PAGE_BYTES)+1 | Column offset from legacy reads |
| start_o | output | 1 | Operation start pulse |
| op_o | output | 4 | Operation code valid with start_o |
| illegal_o | output | 1 | Unknown command pulse |

## Verification
A wrong address count moves every later byte to a different lane, so the error shows on `addr_o` after the next address write. It also shifts the start pulse by a whole byte, which is visible one cycle after the strobe that should have triggered it. A command register that is wrong after a remap or an ignored byte shows as a wrong `cmd_o` in the next cycle, and then as a missing or misplaced start. The bench drives one stimulus stream into three parameter variants and compares each against a behavioural model on every cycle. This exposes capacity-dependent trigger errors at the exact byte where they occur.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [3:0] {
    OP_NONE          = 4'd0,
    OP_READ          = 4'd1,
    OP_READ_ID       = 4'd2,
    OP_STATUS        = 4'd3,
    OP_PROG_SETUP    = 4'd4,
    OP_PROG_CONFIRM  = 4'd5,
    OP_ERASE_SETUP   = 4'd6,
    OP_ERASE_CONFIRM = 4'd7,
    OP_RAND_READ     = 4'd8,
    OP_RESET         = 4'd9
  } nand_op_e;

  typedef enum logic [1:0] {
    OFF_KEEP = 2'd0,
    OFF_ZERO = 2'd1,
    OFF_HALF = 2'd2,
    OFF_PAGE = 2'd3
  } off_sel_e;

  localparam logic [7:0] CMD_READ       = 8'h00;
  localparam logic [7:0] CMD_READ_HI    = 8'h01;
  localparam logic [7:0] CMD_READ_SPARE = 8'h50;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam logic [7:0] CMD_COL_CHG    = 8'h05;
  localparam logic [7:0] CMD_RAND_GO    = 8'hE0;
  localparam logic [7:0] CMD_RAND_GO_NS = 8'h35;
  localparam logic [7:0] CMD_ID         = 8'h90;
  localparam logic [7:0] CMD_RESET      = 8'hFF;
  localparam logic [7:0] CMD_PROG       = 8'h80;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_ERASE      = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_STATUS     = 8'h70;

  typedef struct packed {
    logic       known;
    logic       immediate;
    logic [7:0] eff_cmd;
    off_sel_e   off_sel;
    nand_op_e   op;
  } cmd_info_t;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1
) (
  input  logic [7:0] byte_i,
  input  logic [7:0] cur_cmd_i,
  output cmd_info_t  info_o,
  output logic       skip_o,
  output logic       col_restart_o
);

  always_comb begin
    info_o        = '{known: 1'b1, immediate: 1'b0, eff_cmd: byte_i,
                      off_sel: OFF_KEEP, op: OP_NONE};
    skip_o        = 1'b0;
    col_restart_o = 1'b0;
    if (LARGE_PAGE && byte_i == CMD_READ_GO && cur_cmd_i == CMD_READ) begin
      skip_o = 1'b1;
    end else if (LARGE_PAGE && byte_i == CMD_COL_CHG) begin
      col_restart_o = 1'b1;
    end else begin
      unique case (byte_i)
        CMD_READ:       info_o.off_sel = OFF_ZERO;
        CMD_READ_HI:    begin info_o.eff_cmd = CMD_READ; info_o.off_sel = OFF_HALF; end
        CMD_READ_SPARE: begin info_o.eff_cmd = CMD_READ; info_o.off_sel = OFF_PAGE; end
        CMD_ID, CMD_PROG: ;
        CMD_RESET:      begin info_o.immediate = 1'b1; info_o.op = OP_RESET; end
        CMD_PROG_GO:    begin info_o.immediate = 1'b1; info_o.op = OP_PROG_CONFIRM; end
        CMD_ERASE:      begin info_o.immediate = 1'b1; info_o.op = OP_ERASE_SETUP; end
        CMD_ERASE_GO:   begin info_o.immediate = 1'b1; info_o.op = OP_ERASE_CONFIRM; end
        CMD_STATUS:     begin info_o.immediate = 1'b1; info_o.op = OP_STATUS; end
        CMD_RAND_GO,
        CMD_RAND_GO_NS: begin info_o.immediate = 1'b1; info_o.op = OP_RAND_READ; end
        default:        info_o.known = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/nand_addr_reg.sv
module nand_addr_reg #(
  parameter int BUS_BYTES  = 1,
  parameter int ADDR_BYTES = 5,
  parameter int COL_BITS   = 16,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              clr_col_i,
  input  logic              clr_cnt_i,
  input  logic              load_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              taken_o,
  output logic [CNT_W-1:0]  nxt_cnt_o
);

  localparam logic [CNT_W-1:0]  MAX_CNT  = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0]  WIDEN_AT = CNT_W'(2);
  localparam logic [ADDR_W-1:0] COL_MASK = ADDR_W'((64'd1 << COL_BITS) - 64'd1);

  logic [ADDR_W-1:0] addr_q, base_addr, nxt_addr;
  logic [CNT_W-1:0]  cnt_q, base_cnt, nxt_cnt;

  always_comb begin
    if (clr_all_i)      base_addr = '0;
    else if (clr_col_i) base_addr = addr_q & ~COL_MASK;
    else                base_addr = addr_q;
    base_cnt = (clr_all_i || clr_col_i || clr_cnt_i) ? '0 : cnt_q;
    nxt_addr = base_addr;
    nxt_cnt  = base_cnt;
    taken_o  = load_i && (base_cnt < MAX_CNT);
    if (taken_o) begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (base_cnt == CNT_W'(i)) nxt_addr[8*i +: 8] = byte_i;
      end
      nxt_cnt = base_cnt + 1'b1;
      // word column to byte column
      if (nxt_cnt == WIDEN_AT) nxt_addr = nxt_addr << (BUS_BYTES - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= nxt_addr;
      cnt_q  <= nxt_cnt;
    end
  end

  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
  assign nxt_cnt_o = nxt_cnt;

endmodule

// File: rtl/nand_start_gen.sv
module nand_start_gen
  import nand_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  nand_op_e op_i,
  input  logic     illegal_i,
  output logic     start_o,
  output nand_op_e op_o,
  output logic     illegal_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o   <= 1'b0;
      op_o      <= OP_NONE;
      illegal_o <= 1'b0;
    end else begin
      start_o   <= start_i;
      op_o      <= start_i ? op_i : OP_NONE;
      illegal_o <= illegal_i;
    end
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int BUS_BYTES  = 1,
  parameter bit LARGE_PAGE = 1'b1,
  parameter int CHIP_MBIT  = 2048,
  parameter int PAGE_BYTES = LARGE_PAGE ? 2048 : 512,
  parameter int ADDR_BYTES = 5,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1),
  localparam int OFF_W     = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              ce_ni,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  addr_cnt_o,
  output logic [OFF_W-1:0]  col_off_o,
  output logic              start_o,
  output logic [3:0]        op_o,
  output logic              illegal_o
);

  localparam int COL_BITS = LARGE_PAGE ? 16 : 8;
  localparam int TRIG_INT = !LARGE_PAGE ? 3 : (CHIP_MBIT >= 2048 ? 5 : 4);
  localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG_INT);
  localparam logic [CNT_W-1:0] ID_CNT   = CNT_W'(1);

  cmd_info_t        info;
  logic             skip, col_restart;
  logic [7:0]       cmd_q, cmd_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             cmd_phase, cmd_take, addr_ok;
  logic             clr_all, clr_cnt, clr_col;
  logic             taken;
  logic [CNT_W-1:0] nxt_cnt;
  logic             start_v, illegal_v;
  nand_op_e         op_v, op_q;

  nand_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
    .byte_i       (data_i),
    .cur_cmd_i    (cmd_q),
    .info_o       (info),
    .skip_o       (skip),
    .col_restart_o(col_restart)
  );

  assign cmd_phase = wr_i && !ce_ni && cle_i;
  assign cmd_take  = cmd_phase && info.known && !skip && !col_restart;
  assign addr_ok   = wr_i && ale_i && !(cmd_phase && (skip || col_restart || !info.known));
  assign clr_all   = cmd_take && (info.eff_cmd == CMD_RESET);
  assign clr_cnt   = cmd_take && (info.eff_cmd != CMD_RAND_GO);
  assign clr_col   = cmd_phase && col_restart;
  assign illegal_v = cmd_phase && !info.known;

  always_comb begin
    cmd_d = cmd_q;
    off_d = off_q;
    if (cmd_take) begin
      cmd_d = clr_all ? CMD_READ : info.eff_cmd;
      unique case (info.off_sel)
        OFF_ZERO: off_d = '0;
        OFF_HALF: off_d = OFF_W'(256);
        OFF_PAGE: off_d = OFF_W'(PAGE_BYTES);
        default:  off_d = off_q;
      endcase
      if (clr_all) off_d = '0;
    end
  end

  nand_addr_reg #(
    .BUS_BYTES (BUS_BYTES),
    .ADDR_BYTES(ADDR_BYTES),
    .COL_BITS  (COL_BITS)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(clr_all),
    .clr_col_i(clr_col),
    .clr_cnt_i(clr_cnt),
    .load_i   (addr_ok),
    .byte_i   (data_i),
    .addr_o   (addr_o),
    .cnt_o    (addr_cnt_o),
    .taken_o  (taken),
    .nxt_cnt_o(nxt_cnt)
  );

  // latched commands win over address-triggered starts in the same write
  always_comb begin
    start_v = 1'b0;
    op_v    = OP_NONE;
    if (cmd_take && info.immediate) begin
      start_v = 1'b1;
      op_v    = info.op;
    end else if (taken) begin
      if (cmd_d == CMD_ID && nxt_cnt == ID_CNT) begin
        start_v = 1'b1;
        op_v    = OP_READ_ID;
      end else if (nxt_cnt == TRIG_CNT && cmd_d == CMD_READ) begin
        start_v = 1'b1;
        op_v    = OP_READ;
      end else if (nxt_cnt == TRIG_CNT && cmd_d == CMD_PROG) begin
        start_v = 1'b1;
        op_v    = OP_PROG_SETUP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_READ;
      off_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      off_q <= off_d;
    end
  end

  nand_start_gen u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_v),
    .op_i     (op_v),
    .illegal_i(illegal_v),
    .start_o  (start_o),
    .op_o     (op_q),
    .illegal_o(illegal_o)
  );

  assign op_o      = op_q;
  assign cmd_o     = cmd_q;
  assign col_off_o = off_q;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int ADDR_BYTES = 5,
  parameter int ADDR_W     = 40,
  parameter int CNT_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              ce_ni,
  input logic              cle_i,
  input logic              ale_i,
  input logic [7:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  addr_cnt_o,
  input logic              start_o,
  input logic [3:0]        op_o,
  input logic              illegal_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

  assert_quiet_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !start_o && !illegal_o);

  assert_hold_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cmd_o) && $stable(addr_o) && $stable(addr_cnt_o));

  assert_ce_blocks_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ce_ni && !ale_i |=> $stable(cmd_o) && !start_o && !illegal_o);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ale_i && !cle_i && (addr_cnt_o < FULL) |=> addr_cnt_o == $past(addr_cnt_o) + 1'b1);

  assert_cnt_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ale_i && !cle_i && (addr_cnt_o == FULL) |=> $stable(addr_o) && addr_cnt_o == FULL);

  assert_illegal_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> cmd_o == $past(cmd_o) && addr_cnt_o == $past(addr_cnt_o));

  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, illegal_o}));

  assert_op_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o |-> op_o != 4'd0) and (!start_o |-> op_o == 4'd0));

  assert_id_first_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && op_o == 4'd2 |-> cmd_o == 8'h90 && addr_cnt_o == CNT_W'(1));

  assert_reset_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && op_o == 4'd9 |-> cmd_o == 8'h00 && addr_o == '0 && addr_cnt_o == '0);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(
  .ADDR_BYTES(ADDR_BYTES),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .ce_ni     (ce_ni),
  .cle_i     (cle_i),
  .ale_i     (ale_i),
  .cmd_o     (cmd_o),
  .addr_o    (addr_o),
  .addr_cnt_o(addr_cnt_o),
  .start_o   (start_o),
  .op_o      (op_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_nand_ref.sv
module sim_nand_ref #(
  parameter int INST  = 0,
  parameter int LARGE = 1,
  parameter int MBIT  = 2048,
  parameter int BUSB  = 1,
  parameter int PAGEB = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic        ce_n,
  input logic        cle,
  input logic        ale,
  input logic [7:0]  d,
  input logic [7:0]  a_cmd,
  input logic [39:0] a_addr,
  input logic [2:0]  a_cnt,
  input logic [15:0] a_off,
  input logic        a_start,
  input logic [3:0]  a_op,
  input logic        a_ill
);

  integer n_chk = 0;
  integer n_fail = 0;

  logic [7:0]  e_cmd;
  logic [39:0] e_addr;
  integer      e_cnt, e_off, e_op;
  logic        e_start, e_ill;
  integer      trig;

  initial trig = (LARGE == 0) ? 3 : ((MBIT >= 2048) ? 5 : 4);

  function automatic integer op_of(input logic [7:0] v);
    case (v)
      8'h70: return 3;
      8'h10: return 5;
      8'h60: return 6;
      8'hD0: return 7;
      8'hE0, 8'h35: return 8;
      8'hFF: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic bit known(input logic [7:0] v);
    return (op_of(v) != 0) || v == 8'h00 || v == 8'h01 || v == 8'h50 ||
           v == 8'h90 || v == 8'h80;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_cmd = 8'h00; e_addr = '0; e_cnt = 0; e_off = 0;
      e_start = 0; e_op = 0; e_ill = 0;
    end else begin
      e_start = 0; e_op = 0; e_ill = 0;
      if (wr) begin
        bit blocked;
        logic [7:0] v;
        blocked = 0;
        if (!ce_n && cle) begin
          v = d;
          if (LARGE != 0 && v == 8'h30 && e_cmd == 8'h00) begin
            blocked = 1;
          end else if (LARGE != 0 && v == 8'h05) begin
            e_addr[15:0] = '0; e_cnt = 0; blocked = 1;
          end else if (!known(v)) begin
            e_ill = 1; blocked = 1;
          end else begin
            if (v == 8'h00) e_off = 0;
            if (v == 8'h01) begin e_off = 256; v = 8'h00; end
            if (v == 8'h50) begin e_off = PAGEB; v = 8'h00; end
            e_cmd = v;
            if (v != 8'hE0) e_cnt = 0;
            if (op_of(v) != 0) begin e_start = 1; e_op = op_of(v); end
            if (v == 8'hFF) begin e_cmd = 8'h00; e_addr = '0; e_off = 0; end
          end
        end
        if (ale && !blocked && e_cnt < 5) begin
          e_addr[8*e_cnt +: 8] = d;
          e_cnt = e_cnt + 1;
          if (e_cnt == 2) e_addr = e_addr << (BUSB - 1);
          if (!e_start) begin
            if (e_cnt == 1 && e_cmd == 8'h90) begin e_start = 1; e_op = 2; end
            else if (e_cnt == trig && e_cmd == 8'h00) begin e_start = 1; e_op = 1; end
            else if (e_cnt == trig && e_cmd == 8'h80) begin e_start = 1; e_op = 4; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s inst%0d at %0t: actual %h expected %h", req, INST, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cmd", 64'(a_cmd), 64'(e_cmd));
      chk("R2 addr", 64'(a_addr), 64'(e_addr));
      chk("R9 count", 64'(a_cnt), 64'(e_cnt));
      chk("R3 offset", 64'(a_off), 64'(e_off));
      chk("R11 start", 64'(a_start), 64'(e_start));
      chk("R11 op", 64'(a_op), 64'(e_op));
      chk("R10 illegal", 64'(a_ill), 64'(e_ill));
    end
  end

endmodule

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] din = 8'h00;

  integer n_chk = 0;
  integer n_fail = 0;
  bit     done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  c0, c1, c2;
  logic [39:0] a0, a1, a2;
  logic [2:0]  n0, n1, n2;
  logic [11:0] f0, f2;
  logic [9:0]  f1;
  logic        s0, s1, s2, i0, i1, i2;
  logic [3:0]  o0, o1, o2;

  nand_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .data_i(din), .cmd_o(c0), .addr_o(a0), .addr_cnt_o(n0), .col_off_o(f0),
    .start_o(s0), .op_o(o0), .illegal_o(i0));

  nand_cmd_seq #(.BUS_BYTES(2), .LARGE_PAGE(1'b0), .CHIP_MBIT(128), .PAGE_BYTES(512)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .data_i(din), .cmd_o(c1), .addr_o(a1), .addr_cnt_o(n1), .col_off_o(f1),
    .start_o(s1), .op_o(o1), .illegal_o(i1));

  nand_cmd_seq #(.LARGE_PAGE(1'b1), .CHIP_MBIT(1024)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .data_i(din), .cmd_o(c2), .addr_o(a2), .addr_cnt_o(n2), .col_off_o(f2),
    .start_o(s2), .op_o(o2), .illegal_o(i2));

  sim_nand_ref #(.INST(0), .LARGE(1), .MBIT(2048), .BUSB(1), .PAGEB(2048)) u_r0 (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ce_n(ce_n), .cle(cle), .ale(ale), .d(din),
    .a_cmd(c0), .a_addr(a0), .a_cnt(n0), .a_off({4'b0, f0}), .a_start(s0), .a_op(o0), .a_ill(i0));

  sim_nand_ref #(.INST(1), .LARGE(0), .MBIT(128), .BUSB(2), .PAGEB(512)) u_r1 (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ce_n(ce_n), .cle(cle), .ale(ale), .d(din),
    .a_cmd(c1), .a_addr(a1), .a_cnt(n1), .a_off({6'b0, f1}), .a_start(s1), .a_op(o1), .a_ill(i1));

  sim_nand_ref #(.INST(2), .LARGE(1), .MBIT(1024), .BUSB(1), .PAGEB(2048)) u_r2 (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ce_n(ce_n), .cle(cle), .ale(ale), .d(din),
    .a_cmd(c2), .a_addr(a2), .a_cnt(n2), .a_off({4'b0, f2}), .a_start(s2), .a_op(o2), .a_ill(i2));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic cen, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; ce_n = cen; din = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    bus_wr(1'b1, 1'b0, 1'b0, d);
  endtask

  task automatic adr(input logic [7:0] d);
    bus_wr(1'b0, 1'b1, 1'b0, d);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + u_r0.n_chk + u_r1.n_chk + u_r2.n_chk,
             n_fail + u_r0.n_fail + u_r1.n_fail + u_r2.n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 cmd", 64'(c0), 64'h00);
    check("R13 addr", 64'(a0), 64'h0);
    check("R13 cnt/start/op/ill/off", {n0, s0, o0, i0, f0}, 64'h0);

    // trigger byte depends on class and capacity
    cmd(8'h00);
    adr(8'h11); adr(8'h22);
    adr(8'h33);
    check("R6 small-page start at byte 3", {s1, o1}, {1'b1, 4'd1});
    check("R6 large 2Gb no start at byte 3", 64'(s0), 64'h0);
    adr(8'h44);
    check("R6 large 1Gb start at byte 4", {s2, o2}, {1'b1, 4'd1});
    adr(8'h55);
    check("R6 large 2Gb start at byte 5", {s0, o0}, {1'b1, 4'd1});
    check("R2 address byte order", 64'(a0), 64'h5544332211);
    check("R5 word column widened", 64'(a1), 64'h5544334422);
    adr(8'h66);
    check("R2 sixth byte dropped", 64'(a0), 64'h5544332211);
    check("R2 count saturates", 64'(n0), 64'd5);

    cmd(8'h90);
    check("R9 count cleared by command", 64'(n0), 64'd0);
    adr(8'h00);
    check("R7 read id on first byte", {s0, o0}, {1'b1, 4'd2});

    cmd(8'h01);
    check("R3 0x01 maps to read", 64'(c0), 64'h00);
    check("R3 0x01 offset", 64'(f0), 64'h100);
    cmd(8'h50);
    check("R3 0x50 offset large", 64'(f0), 64'd2048);
    check("R3 0x50 offset small", 64'(f1), 64'd512);
    cmd(8'h00);
    check("R3 0x00 clears offset", 64'(f0), 64'd0);

    adr(8'hAA); adr(8'hBB);
    check("R2 column bytes", 64'(a0), 64'h554433BBAA);
    cmd(8'h05);
    check("R4 column cleared", 64'(a0), 64'h5544330000);
    check("R4 count cleared, cmd kept", {n0, c0}, {3'd0, 8'h00});
    check("R10 0x05 unknown on small page", 64'(i1), 64'h1);
    cmd(8'h30);
    check("R4 0x30 ignored after read", {s0, i0, c0}, {1'b0, 1'b0, 8'h00});
    check("R10 0x30 unknown on small page", 64'(i1), 64'h1);

    cmd(8'h70);
    check("R8 status immediate", {s0, o0}, {1'b1, 4'd3});
    cmd(8'h00); adr(8'h12); adr(8'h34);
    cmd(8'hE0);
    check("R8 random read immediate", {s0, o0}, {1'b1, 4'd8});
    check("R9 0xE0 keeps count", 64'(n0), 64'd2);
    cmd(8'h35);
    check("R8 0x35 immediate", {s0, o0}, {1'b1, 4'd8});
    cmd(8'h60);
    check("R8 erase setup immediate", {s0, o0}, {1'b1, 4'd6});
    adr(8'h01); adr(8'h02); adr(8'h03);
    cmd(8'hD0);
    check("R8 erase confirm immediate", {s0, o0}, {1'b1, 4'd7});
    cmd(8'h80);
    check("R6 program setup no start on latch", 64'(s0), 64'h0);
    for (int k = 0; k < 4; k++) adr(8'(k + 1));
    check("R6 program setup waits", 64'(s0), 64'h0);
    adr(8'h05);
    check("R6 program setup start", {s0, o0}, {1'b1, 4'd4});
    cmd(8'h10);
    check("R8 program confirm", {s0, o0}, {1'b1, 4'd5});

    cmd(8'h42);
    check("R10 unknown flagged", 64'(i0), 64'h1);
    check("R10 unknown keeps cmd", 64'(c0), 64'h10);
    @(negedge clk);
    check("R11 illegal one cycle", 64'(i0), 64'h0);

    bus_wr(1'b1, 1'b0, 1'b1, 8'h70);
    check("R1 CE high blocks command", {s0, c0}, {1'b0, 8'h10});
    bus_wr(1'b0, 1'b0, 1'b0, 8'h90);
    check("R1 data write no effect", {s0, i0, c0}, {1'b0, 1'b0, 8'h10});

    cmd(8'hFF);
    check("R12 reset start", {s0, o0}, {1'b1, 4'd9});
    check("R12 reset state", {c0, a0, n0, f0}, 64'h0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule